// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models how a NOR-style flash device reports the progress of its internal program and erase algorithms on the data bus when the host reads status. It keeps an operation state: array read, programming, erasing, erase suspended, programming while erase is suspended, a short lockout after a program aimed at a protected sector, and a timeout state. It also keeps the set of sectors chosen for the current erase. Each read strobe returns a byte built from that state. Two toggle bits, a timeout flag and the sector under the read address decide its value.

Commands arrive as single-cycle strobes: start program (with the target address), start erase (with a sector-selection mask), suspend, resume and reset. A separate pulse strobe marks each internal program or erase pulse, and a verify input says whether that pulse finished the job. The host tells the two toggle bits apart to learn whether the device is busy, and whether a given sector is part of an erase that is running or suspended.

Top module: `flash_status_gen`

## Requirements
- R1: After a synchronous active-low reset the state is array read, both toggle bits are 0, and `dq_o` is 0x00.
- R2: A read (`rd_i` high for one cycle) updates `dq_o` at the next clock edge, and `dq_o` holds its value between reads. In array read the byte is 0x00 (array data modelled as zero), and bit 6 and bit 2 keep their internal values for the next operation.
- R3: While a program or erase is running, every read inverts bit 6 of the returned status byte. Status bits not named here (7, 4, 3, 1, 0) read 0.
- R4: In erase-suspend, reads return the status byte with bit 6 unchanged. During a program issued while erase is suspended, bit 6 inverts on each read. When that program finishes, the state goes back to erase-suspend and bit 6 stops inverting.
- R5: Bit 2 inverts only on reads whose sector (`addr_i[ADDR_W-1 -: log2(NUM_SECTORS)]`) was selected by the erase mask. This applies in erasing, erase-suspended and program-while-suspended states. On any other read it keeps its value.
- R6: Suspend moves a running erase to erase-suspend. Resume moves it back. Pulse strobes are ignored while suspended, and a program aimed at a protected sector is ignored while suspended.
- R7: A program whose target sector is set in `PROT_MASK` inverts bit 6 on reads for `CLK_MHZ*PROT_US` clock cycles. After that the device returns to array read and accepts new commands.
- R8: Each pulse strobe with `verify_ok_i` low adds one to the operation's pulse count. The strobe that brings the count to `PULSE_LIMIT` enters the timeout state, and status reads then return bit 5 = 1. One fewer failing pulse leaves bit 5 at 0.
- R9: In the timeout state, program, erase, suspend and resume commands are ignored. Reads still return bit 5 = 1 with bit 6 inverting.
- R10: A reset command leaves the timeout state for array read, after which new commands are accepted. A reset command while a program or erase is running is ignored.
- R11: A program started with `nonblank_i` high ends at its first pulse strobe and returns to array read with bit 5 = 0.
- R12: A pulse strobe with `verify_ok_i` high ends a program or erase. The state returns to array read, or to erase-suspend for a program issued during suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_i | input | 1 | Status/array read strobe |
| addr_i | input | ADDR_W | Read or program address; the upper bits select the sector |
| cmd_prog_i | input | 1 | Start program at `addr_i` |
| cmd_erase_i | input | 1 | Start erase of the sectors in `erase_sel_i` |
| erase_sel_i | input | NUM_SECTORS | Sector-selection mask captured with the erase command |
| cmd_susp_i | input | 1 | Suspend a running erase |
| cmd_resume_i | input | 1 | Resume a suspended erase |
| cmd_reset_i | input | 1 | Reset command (leaves the timeout state) |
| tick_i | input | 1 | One internal program/erase pulse has elapsed |
| verify_ok_i | input | 1 | The pulse marked by `tick_i` completed the operation |
| nonblank_i | input | 1 | The program target is not blank; captured with the program command |
| dq_o | output | 8 | Returned byte: bit 6 and bit 2 toggle bits, bit 5 timeout flag |

## Verification
The properties assume that the command strobes are one cycle wide and that at most one command is raised in any cycle. They also assume that `erase_sel_i` and `nonblank_i` are valid in the cycle their command is raised. The bench drives every strobe on the falling edge for exactly one cycle, and it spaces commands by at least one idle cycle. It never raises a read and a command together. Pulse strobes are issued only when the scenario calls for a pulse. Each task then reads back through `dq_o` to confirm the state it reached.

// File: rtl/flash_stat_pkg.sv
// Shared types for the flash status generator.
// Assumes nothing beyond being compiled first.
package flash_stat_pkg;

    typedef enum logic [2:0] {
        ST_READ    = 3'd0,
        ST_PROG    = 3'd1,
        ST_ERASE   = 3'd2,
        ST_ESUSP   = 3'd3,
        ST_ESPROG  = 3'd4,
        ST_PROTWIN = 3'd5,
        ST_TIMEOUT = 3'd6
    } op_state_e;

    localparam int BIT_TOG6 = 6;
    localparam int BIT_TOUT = 5;
    localparam int BIT_TOG2 = 2;

endpackage

// File: rtl/flash_cnt.sv
// Saturating-free event counter with a terminal hit flag.
// hit_o is high in the cycle whose increment reaches LIMIT; the count then wraps to 0.
// Assumes LIMIT >= 1.
module flash_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic hit_o
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign hit_o = inc_i && (cnt_q == W'(LIMIT - 1));

    // Count increments, clearing on request or on reaching the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (inc_i)  cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/flash_sector_dec.sv
// Decodes the sector field of an address into membership flags for the
// erase-selection mask and the protection mask.
// Assumes NUM_SECTORS is a power of two, at least 2.
module flash_sector_dec #(
    parameter int NUM_SECTORS = 8,
    parameter int SEC_W       = $clog2(NUM_SECTORS)
) (
    input  logic [SEC_W-1:0]       sec_i,
    input  logic [NUM_SECTORS-1:0] sel_mask_i,
    input  logic [NUM_SECTORS-1:0] prot_mask_i,
    output logic                   in_sel_o,
    output logic                   in_prot_o
);
    logic [NUM_SECTORS-1:0] hit_vec;

    // One-hot sector decode.
    for (genvar s = 0; s < NUM_SECTORS; s++) begin : g_sec
        assign hit_vec[s] = (sec_i == SEC_W'(s));
    end

    // Mask membership of the addressed sector.
    always_comb begin
        in_sel_o  = |(hit_vec & sel_mask_i);
        in_prot_o = |(hit_vec & prot_mask_i);
    end

endmodule

// File: rtl/flash_op_ctrl.sv
// Operation state machine: accepts command strobes, counts program/erase
// pulses and the protected-program window, and enters timeout at the pulse limit.
// Assumes single-cycle command strobes, at most one per cycle.
module flash_op_ctrl
    import flash_stat_pkg::*;
#(
    parameter int NUM_SECTORS = 8,
    parameter int PULSE_LIMIT = 16,
    parameter int WIN_CYCLES  = 250
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_prog_i,
    input  logic                   cmd_erase_i,
    input  logic [NUM_SECTORS-1:0] erase_sel_i,
    input  logic                   cmd_susp_i,
    input  logic                   cmd_resume_i,
    input  logic                   cmd_reset_i,
    input  logic                   tick_i,
    input  logic                   verify_ok_i,
    input  logic                   nonblank_i,
    input  logic                   in_prot_i,
    output op_state_e              state_o,
    output logic [NUM_SECTORS-1:0] sel_mask_o
);
    op_state_e state_q, state_d;
    logic      nb_q;
    logic      prog_start, erase_start, win_start;
    logic      in_prog, prog_done, prog_fail, erase_run, erase_fail;
    logic      prog_hit, erase_hit, win_hit;

    // Command acceptance and pulse classification.
    always_comb begin
        prog_start  = cmd_prog_i && !in_prot_i &&
                      (state_q == ST_READ || state_q == ST_ESUSP);
        win_start   = cmd_prog_i && in_prot_i && (state_q == ST_READ);
        erase_start = cmd_erase_i && !cmd_prog_i && (state_q == ST_READ);
        in_prog     = (state_q == ST_PROG) || (state_q == ST_ESPROG);
        prog_done   = in_prog && tick_i && (verify_ok_i || nb_q);
        prog_fail   = in_prog && tick_i && !verify_ok_i && !nb_q;
        erase_run   = (state_q == ST_ERASE) && !cmd_susp_i;
        erase_fail  = erase_run && tick_i && !verify_ok_i;
    end

    flash_cnt #(.LIMIT(PULSE_LIMIT)) u_prog_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(prog_start),
        .inc_i(prog_fail), .hit_o(prog_hit)
    );

    flash_cnt #(.LIMIT(PULSE_LIMIT)) u_erase_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(erase_start),
        .inc_i(erase_fail), .hit_o(erase_hit)
    );

    flash_cnt #(.LIMIT(WIN_CYCLES)) u_win_cnt (
        .clk(clk), .rst_n(rst_n), .clr_i(win_start),
        .inc_i(state_q == ST_PROTWIN), .hit_o(win_hit)
    );

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READ: begin
                if (win_start)        state_d = ST_PROTWIN;
                else if (prog_start)  state_d = ST_PROG;
                else if (erase_start) state_d = ST_ERASE;
            end
            ST_PROG: begin
                if (prog_done)        state_d = ST_READ;
                else if (prog_hit)    state_d = ST_TIMEOUT;
            end
            ST_ERASE: begin
                if (cmd_susp_i)                      state_d = ST_ESUSP;
                else if (tick_i && verify_ok_i)      state_d = ST_READ;
                else if (erase_hit)                  state_d = ST_TIMEOUT;
            end
            ST_ESUSP: begin
                if (cmd_resume_i)     state_d = ST_ERASE;
                else if (prog_start)  state_d = ST_ESPROG;
            end
            ST_ESPROG: begin
                if (prog_done)        state_d = ST_ESUSP;
                else if (prog_hit)    state_d = ST_TIMEOUT;
            end
            ST_PROTWIN: begin
                if (win_hit)          state_d = ST_READ;
            end
            ST_TIMEOUT: begin
                if (cmd_reset_i)      state_d = ST_READ;
            end
            default:                  state_d = ST_READ;
        endcase
    end

    // State, erase-selection and non-blank registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_READ;
            sel_mask_o <= '0;
            nb_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (erase_start) sel_mask_o <= erase_sel_i;
            if (prog_start)  nb_q       <= nonblank_i;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/flash_status_byte.sv
// Builds the byte returned on each read strobe from the operation state
// and keeps the two toggle bits between reads.
// Assumes state_i and in_sel_i refer to the same cycle as rd_i.
module flash_status_byte
    import flash_stat_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_i,
    input  op_state_e state_i,
    input  logic      in_sel_i,
    output logic [7:0] dq_o,
    output logic      q6_o,
    output logic      q2_o
);
    logic       tog6, tog2, shows_status;
    logic       q6_n, q2_n;
    logic [7:0] stat_byte;

    // Decide which bits invert on this read and form the status byte.
    always_comb begin
        tog6 = (state_i == ST_PROG)   || (state_i == ST_ERASE) ||
               (state_i == ST_ESPROG) || (state_i == ST_PROTWIN) ||
               (state_i == ST_TIMEOUT);
        tog2 = in_sel_i && ((state_i == ST_ERASE) || (state_i == ST_ESUSP) ||
                            (state_i == ST_ESPROG));
        shows_status = (state_i != ST_READ);
        q6_n = q6_o ^ tog6;
        q2_n = q2_o ^ tog2;
        stat_byte = 8'h00;
        stat_byte[BIT_TOG6] = q6_n;
        stat_byte[BIT_TOUT] = (state_i == ST_TIMEOUT);
        stat_byte[BIT_TOG2] = q2_n;
    end

    // Register toggle bits and the bus byte on each read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q6_o <= 1'b0;
            q2_o <= 1'b0;
            dq_o <= 8'h00;
        end else if (rd_i) begin
            q6_o <= q6_n;
            q2_o <= q2_n;
            dq_o <= shows_status ? stat_byte : 8'h00;
        end
    end

endmodule

// File: rtl/flash_status_gen.sv
// Top: flash embedded-operation status generator. Ties the sector decoder,
// operation controller and status byte builder together.
// Assumes NUM_SECTORS is a power of two and ADDR_W exceeds its log2.
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int                   NUM_SECTORS = 8,
    parameter int                   ADDR_W      = 12,
    parameter logic [NUM_SECTORS-1:0] PROT_MASK = 8'b0000_1000,
    parameter int                   PULSE_LIMIT = 16,
    parameter int                   CLK_MHZ     = 125,
    parameter int                   PROT_US     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   cmd_prog_i,
    input  logic                   cmd_erase_i,
    input  logic [NUM_SECTORS-1:0] erase_sel_i,
    input  logic                   cmd_susp_i,
    input  logic                   cmd_resume_i,
    input  logic                   cmd_reset_i,
    input  logic                   tick_i,
    input  logic                   verify_ok_i,
    input  logic                   nonblank_i,
    output logic [7:0]             dq_o
);
    localparam int SEC_W      = $clog2(NUM_SECTORS);
    localparam int WIN_CYCLES = CLK_MHZ * PROT_US;

    op_state_e              st;
    logic [NUM_SECTORS-1:0] sel_mask;
    logic                   hit_sel, hit_prot;
    logic                   q6_w, q2_w;

    flash_sector_dec #(.NUM_SECTORS(NUM_SECTORS), .SEC_W(SEC_W)) u_dec (
        .sec_i      (addr_i[ADDR_W-1 -: SEC_W]),
        .sel_mask_i (sel_mask),
        .prot_mask_i(PROT_MASK),
        .in_sel_o   (hit_sel),
        .in_prot_o  (hit_prot)
    );

    flash_op_ctrl #(
        .NUM_SECTORS(NUM_SECTORS), .PULSE_LIMIT(PULSE_LIMIT), .WIN_CYCLES(WIN_CYCLES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_prog_i(cmd_prog_i), .cmd_erase_i(cmd_erase_i), .erase_sel_i(erase_sel_i),
        .cmd_susp_i(cmd_susp_i), .cmd_resume_i(cmd_resume_i), .cmd_reset_i(cmd_reset_i),
        .tick_i(tick_i), .verify_ok_i(verify_ok_i), .nonblank_i(nonblank_i),
        .in_prot_i(hit_prot), .state_o(st), .sel_mask_o(sel_mask)
    );

    flash_status_byte u_byte (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .state_i(st), .in_sel_i(hit_sel),
        .dq_o(dq_o), .q6_o(q6_w), .q2_o(q2_w)
    );

endmodule

// File: rtl/flash_status_chk.sv
// Property checker for flash_status_gen, attached by bind.
// Assumes the input conventions listed in the brief.
module flash_status_chk
    import flash_stat_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_i,
    input logic       cmd_reset_i,
    input logic       tick_i,
    input op_state_e  st,
    input logic       hit_sel,
    input logic       q6_w,
    input logic       q2_w,
    input logic [7:0] dq_o
);
    // R3: an active read inverts bit 6
    a_r3_q6_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && (st == ST_PROG || st == ST_ERASE)) |=> (q6_w != $past(q6_w)));

    // R4: erase-suspend reads keep bit 6
    a_r4_q6_held_susp: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st == ST_ESUSP) |=> $stable(q6_w));

    // R5: reads outside selected sectors keep bit 2
    a_r5_q2_held_unsel: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !hit_sel) |=> $stable(q2_w));

    // R2: array-read reads return zero
    a_r2_array_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && st == ST_READ) |=> (dq_o == 8'h00));

    // R8: timeout flag appears only following a pulse strobe
    a_r8_tout_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_TIMEOUT) |-> $past(tick_i));

    // R9: timeout persists without a reset command
    a_r9_tout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TIMEOUT && !cmd_reset_i) |=> (st == ST_TIMEOUT));

    // R10: reset command leaves timeout
    a_r10_reset_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TIMEOUT && cmd_reset_i) |=> (st == ST_READ));

endmodule

bind flash_status_gen flash_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .cmd_reset_i(cmd_reset_i),
    .tick_i(tick_i), .st(st), .hit_sel(hit_sel), .q6_w(q6_w), .q2_w(q2_w),
    .dq_o(dq_o)
);

// File: tb/tb_flash_status_gen.sv
module tb_flash_status_gen;

    localparam int NS = 8;
    localparam int AW = 12;
    localparam int LIM = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_i = 0, cmd_prog_i = 0, cmd_erase_i = 0, cmd_susp_i = 0;
    logic cmd_resume_i = 0, cmd_reset_i = 0, tick_i = 0, verify_ok_i = 0, nonblank_i = 0;
    logic [AW-1:0] addr_i = '0;
    logic [NS-1:0] erase_sel_i = '0;
    logic [7:0] dq_o;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit eq6 = 0, eq2 = 0;

    always #4 clk = ~clk;

    flash_status_gen #(.NUM_SECTORS(NS), .ADDR_W(AW), .PROT_MASK(8'b0000_1000),
                       .PULSE_LIMIT(LIM), .CLK_MHZ(125), .PROT_US(2)) dut (
        .clk(clk), .rst_n(rst_n), .rd_i(rd_i), .addr_i(addr_i),
        .cmd_prog_i(cmd_prog_i), .cmd_erase_i(cmd_erase_i), .erase_sel_i(erase_sel_i),
        .cmd_susp_i(cmd_susp_i), .cmd_resume_i(cmd_resume_i), .cmd_reset_i(cmd_reset_i),
        .tick_i(tick_i), .verify_ok_i(verify_ok_i), .nonblank_i(nonblank_i),
        .dq_o(dq_o)
    );

    function automatic logic [AW-1:0] sec_addr(input int s);
        return AW'(s) << (AW - 3);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    // Read sector s; t6/t2 say whether the toggle bits should invert, vis whether status shows.
    task automatic rd_chk(input string req, input int s, input bit t6, input bit t2,
                          input bit q5, input bit vis);
        logic [7:0] e;
        @(negedge clk); rd_i = 1; addr_i = sec_addr(s);
        @(negedge clk); rd_i = 0;
        eq6 ^= t6; eq2 ^= t2;
        e = vis ? {1'b0, eq6, q5, 2'b00, eq2, 2'b00} : 8'h00;
        chk(req, dq_o, e);
    endtask

    task automatic pulse_prog(input int s, input bit nb);
        @(negedge clk); cmd_prog_i = 1; addr_i = sec_addr(s); nonblank_i = nb;
        @(negedge clk); cmd_prog_i = 0; nonblank_i = 0;
    endtask

    task automatic pulse_erase(input logic [NS-1:0] m);
        @(negedge clk); cmd_erase_i = 1; erase_sel_i = m;
        @(negedge clk); cmd_erase_i = 0;
    endtask

    task automatic tick(input bit ok);
        @(negedge clk); tick_i = 1; verify_ok_i = ok;
        @(negedge clk); tick_i = 0; verify_ok_i = 0;
    endtask

    task automatic t_reset;
        chk("R1 reset dq", dq_o, 8'h00);
        rd_chk("R1 R2 idle read", 0, 0, 0, 0, 0);
    endtask

    task automatic t_program;
        pulse_prog(0, 0);
        rd_chk("R3 prog read1", 0, 1, 0, 0, 1);
        rd_chk("R3 prog read2", 0, 1, 0, 0, 1);
        @(negedge clk); cmd_reset_i = 1; @(negedge clk); cmd_reset_i = 0;
        rd_chk("R10 reset ignored in prog", 0, 1, 0, 0, 1);
        tick(1);
        rd_chk("R12 prog done", 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk("R2 dq holds", dq_o, 8'h00);
    endtask

    task automatic t_erase_suspend;
        pulse_erase(8'b0000_0110);
        rd_chk("R3 R5 erase sel", 1, 1, 1, 0, 1);
        rd_chk("R5 erase unsel", 5, 1, 0, 0, 1);
        @(negedge clk); cmd_susp_i = 1; @(negedge clk); cmd_susp_i = 0;
        rd_chk("R4 R5 susp sel", 1, 0, 1, 0, 1);
        rd_chk("R4 R5 susp unsel", 5, 0, 0, 0, 1);
        tick(1);
        rd_chk("R6 tick ignored in susp", 2, 0, 1, 0, 1);
        pulse_prog(3, 0);
        rd_chk("R6 prot prog ignored in susp", 5, 0, 0, 0, 1);
        pulse_prog(5, 0);
        rd_chk("R4 esprog unsel", 5, 1, 0, 0, 1);
        rd_chk("R4 R5 esprog sel", 2, 1, 1, 0, 1);
        tick(1);
        rd_chk("R4 R12 back to susp", 2, 0, 1, 0, 1);
        @(negedge clk); cmd_resume_i = 1; @(negedge clk); cmd_resume_i = 0;
        rd_chk("R6 resumed", 1, 1, 1, 0, 1);
        tick(1);
        rd_chk("R12 erase done", 1, 0, 0, 0, 0);
    endtask

    task automatic t_protected;
        pulse_prog(3, 0);
        rd_chk("R7 window read1", 3, 1, 0, 0, 1);
        repeat (232) @(negedge clk);
        rd_chk("R7 window late", 3, 1, 0, 0, 1);
        repeat (20) @(negedge clk);
        rd_chk("R7 window over", 3, 0, 0, 0, 0);
        pulse_prog(0, 0);
        rd_chk("R7 new cmd accepted", 0, 1, 0, 0, 1);
        tick(1);
    endtask

    task automatic t_timeout;
        pulse_prog(1, 0);
        repeat (LIM - 1) tick(0);
        rd_chk("R8 below limit", 1, 1, 0, 0, 1);
        tick(0);
        rd_chk("R8 at limit", 1, 1, 0, 1, 1);
        pulse_erase(8'hFF);
        @(negedge clk); cmd_resume_i = 1; @(negedge clk); cmd_resume_i = 0;
        rd_chk("R9 cmds ignored", 1, 1, 0, 1, 1);
        @(negedge clk); cmd_reset_i = 1; @(negedge clk); cmd_reset_i = 0;
        rd_chk("R10 reset exits", 1, 0, 0, 0, 0);
        pulse_prog(2, 0);
        rd_chk("R10 accepts new", 2, 1, 0, 0, 1);
        tick(1);
    endtask

    task automatic t_nonblank;
        pulse_prog(4, 1);
        rd_chk("R11 nonblank running", 4, 1, 0, 0, 1);
        tick(0);
        rd_chk("R11 nonblank ends no Q5", 4, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_program();
        t_erase_suspend();
        t_protected();
        t_timeout();
        t_nonblank();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule